// File: doc/BRIEF.md
# Frog Crossing Rule Engine

This block applies the rules of a lane-crossing frog game. Once per video frame a strobe hands it a set of colour-class samples taken from the background layer under the frog and a matching set taken from the moving-object layer, together with the row the frog occupies. It never looks at object coordinates. Instead it infers the terrain (road, grass or river) from the background colours and infers a hazard or a rescue from the object colours. From these it decides whether the frog is riding a log, has been killed, or has reached the goal.

After a death or a win, the block holds the matching flag for a fixed number of clock cycles. It then raises a one-cycle request asking the surrounding game to put the frog back at its start position, and returns itself to the grass terrain. Colour classes are 2-bit codes: 00 black, 01 green, 10 blue, 11 brown. Each colour vector packs NPIX samples, and sample i sits in bits [2i+1:2i].

The machine has five states: GRASS, ROAD, RIVER, DEAD and WIN. GRASS, ROAD and RIVER are the terrain states. DEAD and WIN are the hold states. Transitions out of a terrain state happen only in a cycle where the strobe is high. They are checked in this priority order:
1. **goal**: the frog is in row 0 and any object sample is green, so the machine goes to WIN.
2. **squashed**: the resolved terrain is road and any object sample is not black, so the machine goes to DEAD.
3. **drowned**: the resolved terrain is river and every object sample is black, so the machine goes to DEAD.
4. **terrain move**: otherwise the machine goes to the resolved terrain state.

The resolved terrain is set by the background samples. If all samples are black it is ROAD. If all are green it is GRASS. If all are blue it is RIVER. If the samples are mixed, the current terrain is kept.

The hold states have a single transition, **expire**: when the hold timer runs out, the machine goes back to GRASS.

Top module: `frog_rules`

## Requirements
- R1: After synchronous reset `rst`, dead, win, on_log and frog_reset are 0 and the machine is in GRASS. GRASS has no hazard, so a strobe with mixed background samples and non-black objects causes no death.
- R2: On a strobe, background samples that are all 00 select ROAD, all 01 select GRASS, and all 10 select RIVER. Mixed background samples keep the current terrain.
- R3: On a strobe whose resolved terrain is ROAD, any object sample other than 00 (and no goal condition) enters DEAD. `dead` goes high in the first cycle after that clock edge.
- R4: On a strobe in a terrain state whose resolved terrain is RIVER, any object sample equal to 11 drives `on_log` high combinationally in that same cycle, and the frog does not die. `on_log` is 0 whenever the strobe is low.
- R5: On a strobe whose resolved terrain is RIVER, object samples that are all 00 enter DEAD.
- R6: On a strobe with `frog_row` equal to 0 and any object sample equal to 01, the machine enters WIN. This takes priority over any death condition on the same strobe.
- R7: DEAD holds `dead` high for exactly HOLD_CYCLES cycles. In the following cycle `dead` is 0 and `frog_reset` is 1 for one cycle. After that the machine is in GRASS.
- R8: WIN holds `win` high for exactly HOLD_CYCLES cycles, followed by a single `frog_reset` cycle with `win` low. After that the machine is in GRASS.
- R9: Without a strobe, the colour and row inputs cause no state change: neither hold state is entered and the terrain is kept.
- R10: While in DEAD or WIN, strobes and all colour and row inputs are ignored. The held flag stays high, `on_log` stays 0, and the hold length is unchanged.
- R11: Asserting `rst` during a hold clears the held flag in the next cycle and returns the machine to GRASS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eval | input | 1 | Once-per-frame evaluate strobe |
| bg_cls | input | 2*NPIX | Background colour classes under the frog |
| obj_cls | input | 2*NPIX | Object colour classes under the frog |
| frog_row | input | ROW_W | Row index of the frog, 0 is the goal row |
| dead | output | 1 | Frog killed, high during the DEAD hold |
| win | output | 1 | Goal reached, high during the WIN hold |
| on_log | output | 1 | Frog carried by a log, combinational during the strobe |
| frog_reset | output | 1 | One-cycle request to return the frog to start |

## Verification
`on_log` is due in the same cycle as the strobe, so the bench reads it one time step after it drives the strobe, before the next clock edge. `dead` and `win` first appear one clock edge after the strobe. They last exactly HOLD_CYCLES cycles, and `frog_reset` appears HOLD_CYCLES cycles after the entry edge. The bench drives every input on a falling edge and reads every registered output just after the next falling edge, counting those edges one by one through the hold. Terrain is never read directly. It is inferred by sending a follow-up strobe whose outcome (death or survival) depends on the terrain.

// File: rtl/frog_rules_pkg.sv
package frog_rules_pkg;

    typedef enum logic [1:0] {
        CLS_BLACK = 2'b00,
        CLS_GREEN = 2'b01,
        CLS_BLUE  = 2'b10,
        CLS_BROWN = 2'b11
    } colour_cls_t;

    typedef enum logic [2:0] {
        ST_GRASS = 3'd0,
        ST_ROAD  = 3'd1,
        ST_RIVER = 3'd2,
        ST_DEAD  = 3'd3,
        ST_WIN   = 3'd4
    } frog_state_t;

endpackage

// File: rtl/frog_pixel_census.sv
module frog_pixel_census
    import frog_rules_pkg::*;
#(
    parameter int NPIX = 4
) (
    input  logic [2*NPIX-1:0] cls_vec,
    output logic              all_black,
    output logic              all_green,
    output logic              all_blue,
    output logic              any_green,
    output logic              any_brown,
    output logic              any_nonblack
);

    logic [NPIX-1:0] is_black;
    logic [NPIX-1:0] is_green;
    logic [NPIX-1:0] is_blue;
    logic [NPIX-1:0] is_brown;

    // One decoder per sample, then reduce across the samples.
    for (genvar i = 0; i < NPIX; i++) begin : g_pix
        logic [1:0] code;
        assign code        = cls_vec[2*i +: 2];
        assign is_black[i] = (code == CLS_BLACK);
        assign is_green[i] = (code == CLS_GREEN);
        assign is_blue[i]  = (code == CLS_BLUE);
        assign is_brown[i] = (code == CLS_BROWN);
    end

    assign all_black    = &is_black;
    assign all_green    = &is_green;
    assign all_blue     = &is_blue;
    assign any_green    = |is_green;
    assign any_brown    = |is_brown;
    assign any_nonblack = ~(&is_black);

endmodule

// File: rtl/frog_hold_timer.sv
module frog_hold_timer #(
    parameter int HOLD_CYCLES = 75_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Counts cycles spent in a hold state; restarts from zero on every entry.
    always_ff @(posedge clk) begin
        if (rst || !run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(HOLD_CYCLES));

endmodule

// File: rtl/frog_rules.sv
module frog_rules
    import frog_rules_pkg::*;
#(
    parameter int NPIX        = 4,
    parameter int ROW_W       = 4,
    parameter int HOLD_CYCLES = 75_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eval,
    input  logic [2*NPIX-1:0] bg_cls,
    input  logic [2*NPIX-1:0] obj_cls,
    input  logic [ROW_W-1:0]  frog_row,
    output logic              dead,
    output logic              win,
    output logic              on_log,
    output logic              frog_reset
);

    frog_state_t state, state_nxt, terrain_now;

    logic bg_all_black, bg_all_green, bg_all_blue;
    logic bg_any_green, bg_any_brown, bg_any_nonblack;
    logic ob_all_black, ob_all_green, ob_all_blue;
    logic ob_any_green, ob_any_brown, ob_any_nonblack;
    logic in_terrain, in_hold, hold_done;
    logic goal_hit, hazard_hit;

    frog_pixel_census #(.NPIX(NPIX)) u_bg_census (
        .cls_vec      (bg_cls),
        .all_black    (bg_all_black),
        .all_green    (bg_all_green),
        .all_blue     (bg_all_blue),
        .any_green    (bg_any_green),
        .any_brown    (bg_any_brown),
        .any_nonblack (bg_any_nonblack)
    );

    frog_pixel_census #(.NPIX(NPIX)) u_obj_census (
        .cls_vec      (obj_cls),
        .all_black    (ob_all_black),
        .all_green    (ob_all_green),
        .all_blue     (ob_all_blue),
        .any_green    (ob_any_green),
        .any_brown    (ob_any_brown),
        .any_nonblack (ob_any_nonblack)
    );

    frog_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (in_hold),
        .expired (hold_done)
    );

    assign in_terrain = (state == ST_GRASS) || (state == ST_ROAD) || (state == ST_RIVER);
    assign in_hold    = (state == ST_DEAD) || (state == ST_WIN);

    // Terrain resolved from the background samples; mixed samples keep it.
    always_comb begin
        if (bg_all_black) begin
            terrain_now = ST_ROAD;
        end else if (bg_all_green) begin
            terrain_now = ST_GRASS;
        end else if (bg_all_blue) begin
            terrain_now = ST_RIVER;
        end else begin
            terrain_now = in_terrain ? state : ST_GRASS;
        end
    end

    assign goal_hit   = (frog_row == '0) && ob_any_green;
    assign hazard_hit = ((terrain_now == ST_ROAD)  && ob_any_nonblack) ||
                        ((terrain_now == ST_RIVER) && ob_all_black);

    // Next-state decision: goal, then death, then terrain move.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_GRASS, ST_ROAD, ST_RIVER: begin
                if (eval) begin
                    if (goal_hit) begin
                        state_nxt = ST_WIN;
                    end else if (hazard_hit) begin
                        state_nxt = ST_DEAD;
                    end else begin
                        state_nxt = terrain_now;
                    end
                end
            end
            ST_DEAD, ST_WIN: begin
                if (hold_done) begin
                    state_nxt = ST_GRASS;
                end
            end
            default: state_nxt = ST_GRASS;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_GRASS;
        end else begin
            state <= state_nxt;
        end
    end

    // Mealy outputs.
    always_comb begin
        dead       = 1'b0;
        win        = 1'b0;
        on_log     = 1'b0;
        frog_reset = 1'b0;
        unique case (state)
            ST_GRASS, ST_ROAD, ST_RIVER: begin
                on_log = eval && (terrain_now == ST_RIVER) && ob_any_brown && !goal_hit;
            end
            ST_DEAD: begin
                dead       = !hold_done;
                frog_reset = hold_done;
            end
            ST_WIN: begin
                win        = !hold_done;
                frog_reset = hold_done;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/frog_rules_chk.sv
module frog_rules_chk (
    input logic clk,
    input logic rst,
    input logic eval,
    input logic dead,
    input logic win,
    input logic on_log,
    input logic frog_reset
);

    // R6
    dead_win_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dead && win));

    // R4
    log_needs_eval_chk: assert property (@(posedge clk) disable iff (rst)
        on_log |-> eval);

    // R7
    dead_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dead |=> (dead || frog_reset));

    // R8
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        win |=> (win || frog_reset));

    // R7
    reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frog_reset |=> (!frog_reset && !dead && !win));

    // R9
    no_strobe_no_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!eval && !dead && !win) |=> (!dead && !win));

    // R10
    hold_no_log_chk: assert property (@(posedge clk) disable iff (rst)
        (dead || win) |-> !on_log);

    // R11
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (!dead && !win && !frog_reset));

endmodule

bind frog_rules frog_rules_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .eval       (eval),
    .dead       (dead),
    .win        (win),
    .on_log     (on_log),
    .frog_reset (frog_reset)
);

// File: tb/frog_rules_bench.sv
module frog_rules_bench;

    localparam int NPIX = 4;
    localparam int ROW_W = 4;
    localparam int HOLD = 5;

    localparam logic [7:0] ALL_BLACK = 8'h00;
    localparam logic [7:0] ALL_GREEN = 8'h55;
    localparam logic [7:0] ALL_BLUE  = 8'hAA;
    localparam logic [7:0] MIXED     = 8'h14;
    localparam logic [7:0] ONE_BROWN = 8'h03;
    localparam logic [7:0] ONE_GREEN = 8'h04;
    localparam logic [7:0] ONE_BLUE  = 8'h20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eval = 1'b0;
    logic [2*NPIX-1:0] bg_cls = '0;
    logic [2*NPIX-1:0] obj_cls = '0;
    logic [ROW_W-1:0] frog_row = 4'd3;
    logic dead, win, on_log, frog_reset;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    frog_rules #(.NPIX(NPIX), .ROW_W(ROW_W), .HOLD_CYCLES(HOLD)) u_frog_rules (
        .clk(clk), .rst(rst), .eval(eval), .bg_cls(bg_cls), .obj_cls(obj_cls),
        .frog_row(frog_row), .dead(dead), .win(win), .on_log(on_log),
        .frog_reset(frog_reset)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One strobed frame; returns on_log seen during the strobe.
    // On return the edge has passed and registered outputs are stable.
    task automatic frame(input logic [7:0] bg, input logic [7:0] obj,
                         input logic [3:0] row, output logic lg);
        @(negedge clk);
        bg_cls = bg; obj_cls = obj; frog_row = row; eval = 1'b1;
        #1 lg = on_log;
        @(negedge clk);
        eval = 1'b0;
        #1;
    endtask

    // Called in the first hold cycle. is_win picks which flag is held;
    // inject drives tempting strobes during the hold.
    task automatic check_hold(input string req, input bit is_win, input bit inject);
        for (int i = 0; i < HOLD; i++) begin
            if (inject) begin
                eval = 1'b1;
                bg_cls = (i % 2 == 0) ? ALL_GREEN : ALL_BLUE;
                obj_cls = (i % 2 == 0) ? ONE_GREEN : ONE_BROWN;
                frog_row = 4'd0;
                #1;
                chk("R10", "on_log in hold", int'(on_log), 0);
            end
            chk(req, is_win ? "win held" : "dead held", int'(is_win ? win : dead), 1);
            chk(req, is_win ? "dead in win" : "win in dead", int'(is_win ? dead : win), 0);
            chk(req, "no early frog_reset", int'(frog_reset), 0);
            @(negedge clk);
            eval = 1'b0;
            #1;
        end
        chk(req, "frog_reset at end", int'(frog_reset), 1);
        chk(req, "flag low at end", int'(dead || win), 0);
        @(negedge clk);
        #1;
        chk(req, "frog_reset one cycle", int'(frog_reset), 0);
    endtask

    // Mixed background with a non-black object: death only if not on grass.
    task automatic expect_grass(input string req);
        logic lg;
        frame(MIXED, ONE_BLUE, 4'd3, lg);
        chk(req, "grass: no death", int'(dead), 0);
        frame(ALL_GREEN, ALL_BLACK, 4'd3, lg);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "dead after reset", int'(dead), 0);
        chk("R1", "win after reset", int'(win), 0);
        chk("R1", "frog_reset after reset", int'(frog_reset), 0);
        chk("R1", "on_log after reset", int'(on_log), 0);
        rst = 1'b0;
        expect_grass("R1");
    endtask

    task automatic t_road;
        logic lg;
        frame(ALL_BLACK, ALL_BLACK, 4'd3, lg);
        chk("R2", "clear road no death", int'(dead), 0);
        frame(MIXED, ONE_BLUE, 4'd3, lg);
        chk("R3", "car hit on kept road", int'(dead), 1);
        check_hold("R7", 1'b0, 1'b0);
        expect_grass("R7");
    endtask

    task automatic t_river;
        logic lg;
        frame(ALL_BLUE, ONE_BROWN, 4'd5, lg);
        chk("R4", "on_log during strobe", int'(lg), 1);
        chk("R4", "no death on log", int'(dead), 0);
        chk("R4", "on_log without strobe", int'(on_log), 0);
        frame(ALL_BLUE, ALL_BLACK, 4'd5, lg);
        chk("R5", "drowned", int'(dead), 1);
        check_hold("R7", 1'b0, 1'b0);
        expect_grass("R7");
    endtask

    task automatic t_win;
        logic lg;
        frame(ALL_GREEN, ONE_GREEN, 4'd0, lg);
        chk("R6", "goal reached", int'(win), 1);
        check_hold("R8", 1'b1, 1'b0);
        expect_grass("R8");
        frame(ALL_BLACK, ONE_GREEN, 4'd0, lg);
        chk("R6", "goal beats car", int'(win), 1);
        chk("R6", "no death with goal", int'(dead), 0);
        check_hold("R8", 1'b1, 1'b0);
        expect_grass("R8");
    endtask

    task automatic t_no_strobe;
        logic lg;
        frame(ALL_BLACK, ALL_BLACK, 4'd3, lg);
        @(negedge clk);
        bg_cls = ALL_BLUE; obj_cls = 8'hFF; frog_row = 4'd0;
        repeat (3) begin
            @(negedge clk);
            #1;
            chk("R9", "no death without strobe", int'(dead), 0);
            chk("R9", "no win without strobe", int'(win), 0);
        end
        frame(MIXED, ONE_BLUE, 4'd3, lg);
        chk("R9", "road terrain kept", int'(dead), 1);
        check_hold("R7", 1'b0, 1'b0);
        expect_grass("R9");
    endtask

    task automatic t_ignore_in_hold;
        logic lg;
        frame(ALL_BLACK, ONE_BLUE, 4'd3, lg);
        chk("R3", "car hit on road", int'(dead), 1);
        check_hold("R10", 1'b0, 1'b1);
        expect_grass("R10");
    endtask

    task automatic t_reset_mid_hold;
        logic lg;
        frame(ALL_BLACK, ONE_BLUE, 4'd3, lg);
        chk("R11", "dead before reset", int'(dead), 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R11", "dead cleared by reset", int'(dead), 0);
        chk("R11", "no frog_reset", int'(frog_reset), 0);
        rst = 1'b0;
        expect_grass("R11");
    endtask

    initial begin
        t_reset();
        t_road();
        t_river();
        t_win();
        t_no_strobe();
        t_ignore_in_hold();
        t_reset_mid_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule